// File: doc/BRIEF.md
# Programmable Terminal Output Routing Matrix

This block lets software choose, for each of sixteen bidirectional terminals, whether the terminal drives a signal out or listens. When it drives, software also chooses which internal timing signal it carries. Internal sources, such as an acquisition convert clock or a sample-clock start pulse, arrive as a bus of single-bit lines. A 5-bit select code per terminal picks one of them, and the selection reaches the pad through combinational logic only.

Software programs the block over a plain synchronous bus with address, write data, a write strobe, a read strobe and read data. The registers are one 16-bit direction word and six 16-bit select words. Select fields sit three to a word at 5-bit spacing. The sixth word carries only terminal 15. Each pad is modelled as separate output-value, output-enable and input-value lines. A terminal set as an input passes its pad value back to the core. A terminal set as an output returns zero to the core.

Top module: `term_route_xbar`

## Requirements
- R1: After reset, every direction bit and every select field is zero. `pad_oe` is 0, `pad_o` is 0 and `rdata` is 0.
- R2: The direction word sits at byte address 0x172. Bit n drives `pad_oe[n]`, with 1 meaning output and 0 meaning input.
- R3: Select word k (k = 0..4) sits at byte address 0x1D0 + 2k. Terminal 3k+j (j = 0..2) uses bits 5j+4:5j of that word. Terminal 15 uses bits 4:0 of the word at 0x1DA.
- R4: When terminal n is an output with select code c, `pad_o[n]` equals `src[c]` combinationally, with no clock delay.
- R5: A select code at or above the number of sources (16 by default, so codes 0x10 to 0x1F) drives a constant 0.
- R6: Bit 15 of words 0x1D0 to 0x1D8 and bits 15:5 of word 0x1DA read as zero, and writes to those bits are ignored.
- R7: A read returns the addressed word on `rdata` one cycle after the read strobe, and `rdata` holds between reads. Any other address, odd addresses included, reads as zero.
- R8: `pad_rx[n]` equals `pad_i[n]` when terminal n is an input and 0 when it is an output. `pad_o[n]` is 0 for an input terminal.
- R9: A write takes effect on the clock edge that samples the strobe. A write to an address that maps to no register changes no register.
- R10: Writing 0x0003 to the direction word and 0x0062 to word 0x1D0 routes source 2 to terminal 0 and source 3 to terminal 1, and makes both terminals outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 9 | Byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| src | input | 16 | Internal source signals, bit c selected by code c |
| pad_i | input | 16 | Value seen on each pad |
| pad_o | output | 16 | Value driven toward each pad |
| pad_oe | output | 16 | Output enable per pad |
| pad_rx | output | 16 | Pad input value passed back to the core |

## Verification
Register writes show on `pad_oe` and `pad_o` right after the edge that samples the write strobe. The bench therefore drives strobes for one full cycle from a falling edge and checks at the next falling edge. Source-to-pad and pad-to-core paths are combinational, so a change on `src` or `pad_i` is checked a short delay after it is applied, with no clock edge in between. Read data is due one edge after the read strobe. The bench checks that `rdata` still holds its old value while the strobe is high, and that it carries the new word half a cycle after that edge.

// File: rtl/term_route_xbar.sv
module term_route_xbar #(
  parameter int NT       = 16,
  parameter int SW       = 5,
  parameter int FPR      = 3,
  parameter int NSRC     = 16,
  parameter int ADDR_W   = 9,
  parameter int DW       = 16,
  parameter int DIR_ADDR = 'h172,
  parameter int SEL_BASE = 'h1D0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NSRC-1:0]   src,
  input  logic [NT-1:0]     pad_i,
  output logic [NT-1:0]     pad_o,
  output logic [NT-1:0]     pad_oe,
  output logic [NT-1:0]     pad_rx
);
  localparam int NCODE = 1 << SW;
  localparam int NREG  = (NT + FPR - 1) / FPR;

  logic [NT-1:0]    dir_q;
  logic [SW-1:0]    sel_q [NT];
  logic [NCODE-1:0] src_all;
  logic [NT-1:0]    routed;
  logic [DW-1:0]    rd_word;
  logic             rd_hit;
  logic             dir_hit;

  assign src_all = NCODE'(src);
  assign dir_hit = (addr == ADDR_W'(DIR_ADDR));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dir_q <= '0;
    else if (wr_en && dir_hit) dir_q <= wdata[NT-1:0];

  for (genvar t = 0; t < NT; t++) begin : g_term
    localparam int REG_A = SEL_BASE + 2 * (t / FPR);
    localparam int LSB   = SW * (t % FPR);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sel_q[t] <= '0;
      else if (wr_en && addr == ADDR_W'(REG_A)) sel_q[t] <= wdata[LSB +: SW];

    assign routed[t] = src_all[sel_q[t]];
  end

  assign pad_oe = dir_q;
  assign pad_o  = routed & dir_q;
  assign pad_rx = pad_i & ~dir_q;

  always_comb begin
    rd_word = '0;
    rd_hit  = dir_hit;
    if (dir_hit) rd_word[NT-1:0] = dir_q;
    for (int t = 0; t < NT; t++) begin
      if (addr == ADDR_W'(SEL_BASE + 2 * (t / FPR))) begin
        rd_word[SW * (t % FPR) +: SW] = sel_q[t];
        rd_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_word;

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(DIR_ADDR)) |=> (pad_oe == $past(wdata[NT-1:0])));

  a_r9_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == ADDR_W'(DIR_ADDR)) |=> $stable(pad_oe));

  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_hit) |=> (rdata == '0));

  a_r6_last_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(SEL_BASE + 2 * (NREG - 1))) |=> (rdata[DW-1:SW] == '0));

  a_r8_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_rx & pad_oe) == '0) && ((pad_o & ~pad_oe) == '0));

  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/term_route_xbar_test.sv
module term_route_xbar_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [8:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [15:0] src = '0, pad_i = '0;
  logic [15:0] pad_o, pad_oe, pad_rx;
  int checks = 0, errors = 0;
  logic [4:0]  m_sel [16];
  logic [15:0] m_dir;

  term_route_xbar uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .src(src), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .pad_rx(pad_rx));

  always #2 clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [8:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [8:0] a, output logic [15:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  function automatic logic [15:0] exp_pad();
    logic [15:0] e = '0;
    for (int t = 0; t < 16; t++)
      e[t] = m_dir[t] & ((m_sel[t] < 16) ? src[m_sel[t][3:0]] : 1'b0);
    return e;
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 oe", pad_oe, 16'h0);
    chk("R1 pad_o", pad_o, 16'h0);
    chk("R1 rdata", rdata, 16'h0);
    rd(9'h1D4, d); chk("R1 sel", d, 16'h0);
    rd(9'h172, d); chk("R1 dir", d, 16'h0);
  endtask

  task automatic t_example();
    wr(9'h172, 16'h0003); wr(9'h1D0, 16'h0062);
    m_dir = 16'h0003; m_sel[0] = 5'h2; m_sel[1] = 5'h3; m_sel[2] = 0;
    src = 16'h0004; #1; chk("R10 term0 start", pad_o, 16'h0001);
    src = 16'h0008; #1; chk("R10 term1 convert", pad_o, 16'h0002);
    src = 16'h0100; #1; chk("R10 code8 unused here", pad_o, 16'h0000);
    chk("R2 oe", pad_oe, 16'h0003);
  endtask

  task automatic t_layout();
    logic [15:0] d, w;
    for (int k = 0; k < 6; k++) begin
      w = '0;
      for (int j = 0; j < 3; j++) begin
        int t = 3 * k + j;
        if (t < 16) begin
          m_sel[t] = 5'((t * 5 + 1) % 16);
          w[5*j +: 5] = m_sel[t];
        end
      end
      wr(9'(9'h1D0 + 2 * k), w);
      rd(9'(9'h1D0 + 2 * k), d); chk("R3 readback", d, w);
    end
    wr(9'h172, 16'hFFFF); m_dir = 16'hFFFF;
    chk("R2 all out", pad_oe, 16'hFFFF);
    for (int p = 0; p < 16; p++) begin
      src = 16'(1 << p); #1;
      chk("R3 R4 onehot", pad_o, exp_pad());
    end
    src = 16'hA5C3; #1; chk("R4 mixed", pad_o, exp_pad());
    src = 16'h5A3C; #1; chk("R4 mixed2", pad_o, exp_pad());
  endtask

  task automatic t_unused();
    wr(9'h1DA, 16'h001F); m_sel[15] = 5'h1F;
    wr(9'h1D8, 16'h7E10); m_sel[12] = 5'h10; m_sel[13] = 5'h10; m_sel[14] = 5'h1F;
    src = 16'hFFFF; #1;
    chk("R5 unused codes", pad_o & 16'hF000, 16'h0000);
    chk("R5 full", pad_o, exp_pad());
  endtask

  task automatic t_reserved();
    logic [15:0] d;
    wr(9'h1DA, 16'hFFFF); rd(9'h1DA, d); chk("R6 last word", d, 16'h001F);
    wr(9'h1D0, 16'hFFFF); rd(9'h1D0, d); chk("R6 bit15", d, 16'h7FFF);
  endtask

  task automatic t_readlat();
    logic [15:0] d;
    wr(9'h1D2, 16'h1234);
    rd(9'h1D0, d);
    @(negedge clk); rd_en = 1; addr = 9'h1D2; #1;
    chk("R7 before edge", rdata, 16'h7FFF);
    @(negedge clk); rd_en = 0; addr = 9'h172;
    chk("R7 after edge", rdata, 16'h1234);
    @(negedge clk); chk("R7 hold", rdata, 16'h1234);
    rd(9'h1D1, d); chk("R7 odd addr", d, 16'h0000);
    rd(9'h100, d); chk("R7 unmapped", d, 16'h0000);
  endtask

  task automatic t_stray();
    logic [15:0] d;
    wr(9'h173, 16'h0000); chk("R9 odd write", pad_oe, 16'hFFFF);
    wr(9'h1DC, 16'h7FFF); rd(9'h1D2, d); chk("R9 stray sel", d, 16'h1234);
    @(negedge clk); wr_en = 1; addr = 9'h172; wdata = 16'h00F0; #1;
    chk("R9 before edge", pad_oe, 16'hFFFF);
    @(negedge clk); wr_en = 0;
    chk("R9 after edge", pad_oe, 16'h00F0);
  endtask

  task automatic t_rx();
    pad_i = 16'hFFFF; #1;
    chk("R8 rx", pad_rx, 16'hFF0F);
    chk("R8 pad_o input low", pad_o & ~pad_oe, 16'h0000);
    pad_i = 16'h1234; #1;
    chk("R8 rx2", pad_rx, 16'h1204);
  endtask

  initial begin
    for (int t = 0; t < 16; t++) m_sel[t] = '0;
    m_dir = '0;
    #1; chk("R1 in reset", pad_oe, 16'h0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_example();
    t_layout();
    t_unused();
    t_reserved();
    t_readlat();
    t_stray();
    t_rx();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule